// File: doc/BRIEF.md
# Register Stack with Full/Empty Flags

This block is a last-in, first-out store built from registers. By default it holds sixty-four 8-bit words, and a 6-bit stack pointer selects the word. A client asks for a push by giving a data word, or asks for a pop. The popped word appears on a registered output in the following cycle.

A push moves the pointer forward first and then writes at the new position. A pop reads at the current position first and then moves the pointer back. The pointer returning to zero is the only source of the two status flags: a push that wraps the pointer to zero marks the stack full, and a pop that lands on zero marks it empty. No separate occupancy counter exists.

The block refuses an illegal request and reports it with a one-cycle error pulse. This covers a push while full, a pop while empty, or a push and a pop asked for in the same cycle.

Top module: `reg_stack`

## Requirements
- R1: While reset is high and in the first cycle after it, `sp` is 0, `empty` is 1, `full` is 0, `pop_data` is 0 and all three error outputs are 0.
- R2: An accepted push (push_req=1, pop_req=0, full=0) advances `sp` by one modulo 64 at the next edge, stores `push_data` at the new `sp` value, and clears `empty`.
- R3: An accepted push taken while `sp` is 63 wraps `sp` to 0 and sets `full`. A push from any other pointer value leaves `full` at 0.
- R4: An accepted pop (pop_req=1, push_req=0, empty=0) places the word stored at the current `sp` on `pop_data` in the cycle after the request, moves `sp` back by one, and clears `full`.
- R5: An accepted pop taken while `sp` is 1 brings `sp` to 0 and sets `empty`. A pop from any other pointer value leaves `empty` at 0.
- R6: A push requested alone while `full` is 1 changes neither `sp`, the flags nor the stored words, and raises `ovf_err` for exactly the next cycle.
- R7: A pop requested alone while `empty` is 1 changes neither `sp`, the flags nor `pop_data`, and raises `unf_err` for exactly the next cycle.
- R8: A cycle that requests both push and pop changes no state, and raises `clash_err` for exactly the next cycle. At most one error output is high in any cycle.
- R9: Words come back in the reverse order of their pushes, and the stack holds 64 words before it refuses a push.
- R10: `full` and `empty` are never both 1, and `pop_data` changes only after an accepted pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Request to push `push_data` |
| push_data | input | 8 | Word to push |
| pop_req | input | 1 | Request to pop the top word |
| pop_data | output | 8 | Last popped word, registered |
| sp | output | 6 | Current stack pointer |
| full | output | 1 | Stack holds 64 words |
| empty | output | 1 | Stack holds no word |
| ovf_err | output | 1 | One-cycle pulse: push refused while full |
| unf_err | output | 1 | One-cycle pulse: pop refused while empty |
| clash_err | output | 1 | One-cycle pulse: push and pop requested together |

## Verification
The bench builds the block with its default widths: 8-bit words and a 6-bit pointer. With these widths, filling all 64 slots takes only 64 pushes. This brings the wrap of the pointer to zero, the full flag, the refused push after it, and a full drain back to empty within a short directed run. A random mix of pushes, pops, idles and clashes follows, drawn with a fixed seed. It repeatedly crosses both the wrap edge and the empty edge with data patterns that differ each time.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic clash;
    } stk_err_t;

    localparam stk_err_t NO_ERR = '{ovf: 1'b0, unf: 1'b0, clash: 1'b0};

    function automatic stk_op_e pick_op(input logic push, input logic pop,
                                        input logic full, input logic empty);
        if (push && pop)     return OP_IDLE;
        if (push && !full)   return OP_PUSH;
        if (pop && !empty)   return OP_POP;
        return OP_IDLE;
    endfunction

    function automatic stk_err_t pick_err(input logic push, input logic pop,
                                          input logic full, input logic empty);
        stk_err_t e;
        e       = NO_ERR;
        e.clash = push && pop;
        e.ovf   = push && !pop && full;
        e.unf   = pop && !push && empty;
        return e;
    endfunction

endpackage

// File: rtl/rstk_req_arb.sv
module rstk_req_arb
    import rstk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push_req,
    input  logic     pop_req,
    input  logic     full,
    input  logic     empty,
    output stk_op_e  op,
    output stk_err_t err_q
);

    stk_err_t err_d;

    always_comb begin
        op    = pick_op(push_req, pop_req, full, empty);
        err_d = pick_err(push_req, pop_req, full, empty);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= NO_ERR;
        else     err_q <= err_d;
    end

    // R6
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && full) |=> err_q.ovf);
    // R7
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && empty) |=> err_q.unf);
    // R8
    p_clash_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req) |=> err_q.clash);
    p_one_error_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_q.ovf, err_q.unf, err_q.clash}));

endmodule

// File: rtl/rstk_ptr_flags.sv
module rstk_ptr_flags
    import rstk_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    output logic [PTR_W-1:0] sp,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] ZERO = '0;
    localparam logic [PTR_W-1:0] TOP  = '1;

    logic [PTR_W-1:0] sp_inc;
    logic [PTR_W-1:0] sp_dec;

    always_comb begin
        sp_inc = sp + ONE;
        sp_dec = sp - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= ZERO;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    sp    <= sp_inc;
                    full  <= (sp_inc == ZERO);
                    empty <= 1'b0;
                end
                OP_POP: begin
                    sp    <= sp_dec;
                    empty <= (sp_dec == ZERO);
                    full  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R10
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
    // R2
    p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (sp == PTR_W'($past(sp) + ONE)) && !empty);
    // R4
    p_pop_step_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP) |=> (sp == PTR_W'($past(sp) - ONE)) && !full);
    // R3
    p_wrap_full_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH && sp == TOP) |=> full && (sp == ZERO));
    // R5
    p_land_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP && sp == ONE) |=> empty && (sp == ZERO));
    // R8
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(sp) && $stable(full) && $stable(empty));

endmodule

// File: rtl/rstk_store.sv
module rstk_store
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [PTR_W-1:0]  sp,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_at;

    always_comb wr_at = sp + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (op == OP_PUSH) slots[wr_at] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst)               pop_data <= '0;
        else if (op == OP_POP) pop_data <= slots[sp];
    end

    // R10
    p_dout_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (op != OP_POP) |=> $stable(pop_data));

endmodule

// File: rtl/reg_stack.sv
module reg_stack
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [PTR_W-1:0]  sp,
    output logic              full,
    output logic              empty,
    output logic              ovf_err,
    output logic              unf_err,
    output logic              clash_err
);

    stk_op_e  op;
    stk_err_t err_q;

    rstk_req_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .full     (full),
        .empty    (empty),
        .op       (op),
        .err_q    (err_q)
    );

    rstk_ptr_flags #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .sp    (sp),
        .full  (full),
        .empty (empty)
    );

    rstk_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .sp        (sp),
        .push_data (push_data),
        .pop_data  (pop_data)
    );

    always_comb begin
        ovf_err   = err_q.ovf;
        unf_err   = err_q.unf;
        clash_err = err_q.clash;
    end

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (sp == '0) && empty && !full && (pop_data == '0));

endmodule

// File: tb/reg_stack_tb_top.sv
module reg_stack_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int PW = 6;
    localparam int DEPTH = 1 << PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] pop_data;
    logic [PW-1:0] sp;
    logic          full, empty, ovf_err, unf_err, clash_err;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mdl [DEPTH];
    int            msp;
    bit            mfull, mempty;
    logic [DW-1:0] mdout;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_stack dut_i (
        .clk(clk), .rst(rst), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .sp(sp), .full(full),
        .empty(empty), .ovf_err(ovf_err), .unf_err(unf_err), .clash_err(clash_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_err(input bit p, input bit q, input bit f, input bit e);
        if (p && q) return 1;
        if (p && f) return 4;
        if (q && e) return 2;
        return 0;
    endfunction

    task automatic step(input bit p, input bit q, input logic [DW-1:0] d);
        int    ee;
        string tag;
        push_req  = p;
        pop_req   = q;
        push_data = d;
        ee = exp_err(p, q, mfull, mempty);
        if (p && q)             tag = "R8";
        else if (p && mfull)    tag = "R6";
        else if (q && mempty)   tag = "R7";
        else if (p)             tag = ((msp + 1) % DEPTH == 0) ? "R3" : "R2";
        else if (q)             tag = (msp == 1) ? "R5" : "R4";
        else                    tag = "R10";
        if (ee == 0) begin
            if (p) begin
                msp = (msp + 1) % DEPTH;
                mdl[msp] = d;
                mfull = (msp == 0);
                mempty = 1'b0;
            end else if (q) begin
                mdout = mdl[msp];
                msp = (msp + DEPTH - 1) % DEPTH;
                mempty = (msp == 0);
                mfull = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "sp", int'(sp), msp);
        check(tag, "full", int'(full), int'(mfull));
        check(tag, "empty", int'(empty), int'(mempty));
        check(tag, "pop_data", int'(pop_data), int'(mdout));
        check(tag, "errors", int'({ovf_err, unf_err, clash_err}), ee);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        msp = 0; mfull = 0; mempty = 1; mdout = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "sp", int'(sp), 0);
        check("R1", "empty", int'(empty), 1);
        check("R1", "full", int'(full), 0);
        check("R1", "pop_data", int'(pop_data), 0);
        check("R1", "errors", int'({ovf_err, unf_err, clash_err}), 0);
        rst = 1'b0;
        step(0, 0, 8'h00);
        check("R1", "sp after release", int'(sp), 0);

        // R7: pop on empty stack, R8: clash on empty stack
        step(0, 1, 8'h00);
        step(1, 1, 8'hAA);
        step(0, 0, 8'h00);

        // R9/R3: fill all 64 slots, then refuse one more (R6)
        for (int i = 0; i < DEPTH; i++) step(1, 0, DW'(8'h30 + i * 3));
        check("R9", "full after 64 pushes", int'(full), 1);
        step(1, 0, 8'hEE);
        step(1, 1, 8'h11);
        // R9/R5: drain in reverse order
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(0, 1, 8'h00);
            check("R9", "lifo order", int'(pop_data), int'(DW'(8'h30 + i * 3)));
        end
        check("R9", "empty after drain", int'(empty), 1);
        step(0, 1, 8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 45)      step(1, 0, DW'($urandom));
            else if (r < 85) step(0, 1, DW'($urandom));
            else if (r < 93) step(0, 0, DW'($urandom));
            else             step(1, 1, DW'($urandom));
            if (i == 1500) begin
                for (int k = 0; k < DEPTH + 2; k++) step(1, 0, DW'($urandom));
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule